// File: doc/BRIEF.md
# Shared Power-Down / Interrupt Pin Controller

This block manages one active-low, open-drain pad for a single Ethernet PHY port. The pad serves two roles. After reset it is an input: a low level on it puts the port into power-down. Once management software enables the output role, the same pad becomes an interrupt request line. The block pulls the pad low while an enabled interrupt is pending. Because the output is open-drain, the pads of two ports can share one wired-OR line.

Software reaches three management registers through a simple one-cycle read/write port:

| Address | Contents |
|---|---|
| 0x00 | Basic control; only the power-down bit 11 is held. |
| 0x11 | Interrupt control: output enable on bit 0, interrupt enable on bit 1. |
| 0x12 | Combined mask/status: per-source mask in the low byte, pending flags in the high byte. |

Event pulses for link-status change and energy-detect change are latched as pending flags when their mask bit is set. Reading register 0x12 returns the flags and clears all of them in one step.

Top module: `pdn_irq_pin`

## Requirements
- R1: After reset all held register bits read as zero, `pinDriveLow` is 0, and `powerDown` depends only on the pad level.
- R2: `pinDriveLow` is asserted only while output enable (register 0x11 bit 0) is set.
- R3: While output enable is clear, a low pad level reaches `powerDown` after two rising clock edges of synchronization. Once output enable is set, the pad level has no effect on `powerDown`.
- R4: Register 0x00 bit 11 is readable and writable. While it is set, `powerDown` is 1.
- R5: A pending interrupt drives the pad only while interrupt enable (register 0x11 bit 1) is set.
- R6: In register 0x12, mask bit 5 gates the link-change source and mask bit 6 gates the energy-detect source. A masked event sets status bit 13 (link) or bit 14 (energy). An unmasked event sets nothing. All other bits of the register read zero.
- R7: Both status bits can be pending together. The pad stays driven while any pending bit exists and both enables are set.
- R8: A read of register 0x12 returns the current pending bits and clears all of them at that clock edge. The pad is released from the next cycle on.
- R9: An enabled event that arrives in the same cycle as a read of register 0x12 is still pending after the clear.
- R10: An enabled event drives `pinDriveLow` combinationally in its own cycle, before any clock edge.
- R11: Writes to the status byte (bits 15:8) of register 0x12 leave the pending bits unchanged.
- R12: `regRdData` is zero when no read is requested and for any unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of 0x12 clears the pending flags |
| regAddr | input | 5 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid in the cycle of `regRdEn` |
| linkEvt | input | 1 | Link-status change pulse |
| energyEvt | input | 1 | Energy-detect change pulse |
| pinIn | input | 1 | Sampled level of the shared pad |
| pinDriveLow | output | 1 | Open-drain enable: 1 pulls the pad low |
| powerDown | output | 1 | Effective power-down request for the port |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Read colliding with an event.** A design that clears unconditionally would lose the event, so a later read would show zero where the model expects the flag.
- **Output-enable transition while the pad is held low.** A design that keeps using the synchronized pad level would leave `powerDown` stuck high after the output role is enabled.
- **Two-edge synchronizer latency.** A wrong number of stages would move the `powerDown` edge to a different cycle than the model's.
- **Events with the mask cleared.** These would wrongly raise status flags.
- **Writes of all ones to the status byte.** These would wrongly set flags.
- **Same-cycle pad drive on an enabled event.** A design that waits for the registered flag would show the pad a cycle late.

// File: rtl/pdn_irq_pkg.sv
package pdn_irq_pkg;
  localparam int N_SRC    = 2;   // 0: link change, 1: energy-detect change
  localparam int PD_BIT   = 11;  // power-down in the basic control register
  localparam int OE_BIT   = 0;   // pad output enable in the control register
  localparam int IE_BIT   = 1;   // interrupt enable in the control register
  localparam int MASK_LSB = 5;   // first mask bit in the mask/status register
  localparam int STAT_LSB = 13;  // first pending bit in the mask/status register

  typedef struct packed {
    logic wrBasic;
    logic wrCtrl;
    logic wrMaskStat;
    logic rdBasic;
    logic rdCtrl;
    logic rdMaskStat;
  } regStrobe_t;
endpackage

// File: rtl/pdn_irq_ctrl.sv
module pdn_irq_ctrl
  import pdn_irq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int ADDR_BASIC = 'h00,
  parameter int ADDR_CTRL  = 'h11,
  parameter int ADDR_MSR   = 'h12
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_BASIC = ADDR_W'(ADDR_BASIC);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_MSR   = ADDR_W'(ADDR_MSR);

  logic hitBasic, hitCtrl, hitMsr;

  always_comb begin
    hitBasic = (regAddr == A_BASIC);
    hitCtrl  = (regAddr == A_CTRL);
    hitMsr   = (regAddr == A_MSR);
    strb.wrBasic    = regWrEn & hitBasic;
    strb.wrCtrl     = regWrEn & hitCtrl;
    strb.wrMaskStat = regWrEn & hitMsr;
    strb.rdBasic    = regRdEn & hitBasic;
    strb.rdCtrl     = regRdEn & hitCtrl;
    strb.rdMaskStat = regRdEn & hitMsr;
  end
endmodule

// File: rtl/pdn_irq_dp.sv
module pdn_irq_dp
  import pdn_irq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [N_SRC-1:0]  evtVec,
  input  logic              pinIn,
  output logic [DATA_W-1:0] regRdData,
  output logic              pinDriveLow,
  output logic              powerDown,
  output logic [N_SRC-1:0]  pendVec,
  output logic [N_SRC-1:0]  maskVec,
  output logic              outEn,
  output logic              intEn,
  output logic              pdBit
);
  logic [N_SRC-1:0]       maskQ, pendQ, hitNow;
  logic                   pdQ, oeQ, ieQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   padLowSync;

  // control and basic registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdQ <= 1'b0;
      oeQ <= 1'b0;
      ieQ <= 1'b0;
    end else begin
      if (strb.wrBasic) pdQ <= regWrData[PD_BIT];
      if (strb.wrCtrl) begin
        oeQ <= regWrData[OE_BIT];
        ieQ <= regWrData[IE_BIT];
      end
    end
  end

  // per-source mask and pending flag
  assign hitNow = evtVec & maskQ;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[i] <= 1'b0;
        pendQ[i] <= 1'b0;
      end else begin
        if (strb.wrMaskStat) maskQ[i] <= regWrData[MASK_LSB+i];
        if (strb.rdMaskStat) pendQ[i] <= hitNow[i];
        else if (hitNow[i])  pendQ[i] <= 1'b1;
      end
    end
  end

  // pad synchronizer, idle level high
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= 1'b1;
      else if (s == 0) syncQ[s] <= pinIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign padLowSync = ~syncQ[SYNC_STAGES-1];

  // outputs
  always_comb begin
    pinDriveLow = oeQ & ieQ & ((|pendQ) | (|hitNow));
    powerDown   = pdQ | (~oeQ & padLowSync);
  end

  always_comb begin
    regRdData = '0;
    if (strb.rdBasic) regRdData[PD_BIT] = pdQ;
    if (strb.rdCtrl) begin
      regRdData[OE_BIT] = oeQ;
      regRdData[IE_BIT] = ieQ;
    end
    if (strb.rdMaskStat) begin
      for (int i = 0; i < N_SRC; i++) begin
        regRdData[MASK_LSB+i] = maskQ[i];
        regRdData[STAT_LSB+i] = pendQ[i];
      end
    end
  end

  assign pendVec = pendQ;
  assign maskVec = maskQ;
  assign outEn   = oeQ;
  assign intEn   = ieQ;
  assign pdBit   = pdQ;
endmodule

// File: rtl/pdn_irq_pin.sv
module pdn_irq_pin
  import pdn_irq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BASIC  = 'h00,
  parameter int ADDR_CTRL   = 'h11,
  parameter int ADDR_MSR    = 'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              linkEvt,
  input  logic              energyEvt,
  input  logic              pinIn,
  output logic              pinDriveLow,
  output logic              powerDown
);
  regStrobe_t       strb;
  logic [N_SRC-1:0] pendVec, maskVec;
  logic             outEn, intEn, pdBit;

  pdn_irq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_BASIC(ADDR_BASIC),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_MSR(ADDR_MSR)
  ) u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strb(strb)
  );

  pdn_irq_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .evtVec({energyEvt, linkEvt}), .pinIn(pinIn),
    .regRdData(regRdData), .pinDriveLow(pinDriveLow), .powerDown(powerDown),
    .pendVec(pendVec), .maskVec(maskVec), .outEn(outEn), .intEn(intEn),
    .pdBit(pdBit)
  );
endmodule

// File: rtl/pdn_irq_pin_chk.sv
module pdn_irq_pin_chk #(
  parameter int ADDR_W   = 5,
  parameter int ADDR_MSR = 'h12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              linkEvt,
  input logic              energyEvt,
  input logic              pinDriveLow,
  input logic              powerDown,
  input logic [1:0]        pendVec,
  input logic [1:0]        maskVec,
  input logic              outEn,
  input logic              intEn,
  input logic              pdBit
);
  logic rdMsr;
  assign rdMsr = regRdEn && (regAddr == ADDR_W'(ADDR_MSR));

  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinDriveLow |-> outEn);
  // R5
  ie_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinDriveLow |-> intEn);
  // R4
  pd_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdBit |-> powerDown);
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdMsr && !linkEvt && !energyEvt) |=> (pendVec == 2'b00));
  // R9
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdMsr && linkEvt && maskVec[0]) |=> pendVec[0]);
  // R10
  async_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((linkEvt && maskVec[0]) || (energyEvt && maskVec[1])) && outEn && intEn)
      |-> pinDriveLow);
  // R11
  no_spont_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!linkEvt && !energyEvt) |=> ((pendVec & ~$past(pendVec)) == 2'b00));
endmodule

bind pdn_irq_pin pdn_irq_pin_chk #(.ADDR_W(ADDR_W), .ADDR_MSR(ADDR_MSR)) u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
  .linkEvt(linkEvt), .energyEvt(energyEvt), .pinDriveLow(pinDriveLow),
  .powerDown(powerDown), .pendVec(pendVec), .maskVec(maskVec),
  .outEn(outEn), .intEn(intEn), .pdBit(pdBit)
);

// File: tb/pdn_irq_pin_tb.sv
module pdn_irq_pin_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        linkEvt = 1'b0, energyEvt = 1'b0;
  logic        pinExt = 1'b1;
  logic        pinIn;
  logic        pinDriveLow, powerDown;

  int    nChecks = 0, nFails = 0, cycles = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // reference model state
  bit mPd, mOe, mIe, mMaskL, mMaskE, mPendL, mPendE, mS1, mS2;

  always #2 clk = ~clk;  // 250 MHz

  assign pinIn = pinExt & ~pinDriveLow;  // wired open-drain pad

  pdn_irq_pin u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .linkEvt(linkEvt), .energyEvt(energyEvt), .pinIn(pinIn),
    .pinDriveLow(pinDriveLow), .powerDown(powerDown)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead();
    logic [15:0] v = '0;
    if (regRdEn) begin
      case (regAddr)
        5'h00: v[11] = mPd;
        5'h11: v[1:0] = {mIe, mOe};
        5'h12: begin
          v[5] = mMaskL; v[6] = mMaskE; v[13] = mPendL; v[14] = mPendE;
        end
        default: v = '0;  // R12
      endcase
    end
    return v;
  endfunction

  // model update on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      {mPd, mOe, mIe, mMaskL, mMaskE, mPendL, mPendE} = '0;
      mS1 = 1'b1; mS2 = 1'b1;
    end else begin
      bit hl, he;
      hl = linkEvt & mMaskL;
      he = energyEvt & mMaskE;
      mS2 = mS1; mS1 = pinIn;
      if (regRdEn && regAddr == 5'h12) begin mPendL = hl; mPendE = he; end
      else begin mPendL |= hl; mPendE |= he; end
      if (regWrEn) begin
        case (regAddr)
          5'h00: mPd = regWrData[11];
          5'h11: begin mOe = regWrData[0]; mIe = regWrData[1]; end
          5'h12: begin mMaskL = regWrData[5]; mMaskE = regWrData[6]; end
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      check(curReq, "pinDriveLow", {15'b0, pinDriveLow},
            {15'b0, mOe & mIe & (mPendL | mPendE | (linkEvt & mMaskL) | (energyEvt & mMaskE))});
      check(curReq, "powerDown", {15'b0, powerDown}, {15'b0, mPd | (~mOe & ~mS2)});
      check(curReq, "regRdData", regRdData, expRead());
    end
  end

  task automatic cyc(bit wr, bit rd, logic [4:0] a, logic [15:0] d, bit l, bit e);
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d;
    linkEvt = l; energyEvt = e;
    @(posedge clk);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 5'h00, 16'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", "pinDriveLow after reset", {15'b0, pinDriveLow}, 16'h0);
    check("R1", "powerDown after reset", {15'b0, powerDown}, 16'h0);
    cyc(0, 1, 5'h00, 0, 0, 0); cyc(0, 1, 5'h11, 0, 0, 0); cyc(0, 1, 5'h12, 0, 0, 0);
    // R12 unmapped and idle reads
    curReq = "R12"; cyc(0, 1, 5'h05, 0, 0, 0); idle(1);
    // R3 pad low reaches powerDown after two edges
    curReq = "R3";
    @(negedge clk) pinExt = 1'b0;
    idle(4);
    cyc(1, 0, 5'h11, 16'h0001, 0, 0);  // output role: pad ignored
    idle(3);
    cyc(1, 0, 5'h11, 16'h0000, 0, 0);
    idle(3);
    @(negedge clk) pinExt = 1'b1;
    idle(3);
    // R4 basic power-down bit
    curReq = "R4";
    cyc(1, 0, 5'h00, 16'hFFFF, 0, 0); cyc(0, 1, 5'h00, 0, 0, 0);
    cyc(1, 0, 5'h00, 16'h0000, 0, 0); cyc(0, 1, 5'h00, 0, 0, 0);
    // R6 unmasked events set nothing
    curReq = "R6";
    cyc(1, 0, 5'h11, 16'h0003, 0, 0);
    cyc(0, 0, 5'h00, 0, 1, 1); cyc(0, 1, 5'h12, 0, 0, 0);
    // R11 status byte writes ignored
    curReq = "R11";
    cyc(1, 0, 5'h12, 16'hFF60, 0, 0); cyc(0, 1, 5'h12, 0, 0, 0); idle(1);
    // R10 + R7 both sources, same-cycle drive
    curReq = "R10";
    cyc(0, 0, 5'h00, 0, 1, 0); idle(1);
    curReq = "R7";
    cyc(0, 0, 5'h00, 0, 0, 1); idle(2);
    // R8 read clears all, pad released
    curReq = "R8";
    cyc(0, 1, 5'h12, 0, 0, 0); idle(2); cyc(0, 1, 5'h12, 0, 0, 0);
    // R9 event during read survives
    curReq = "R9";
    cyc(0, 0, 5'h00, 0, 0, 1);
    cyc(0, 1, 5'h12, 0, 1, 0); idle(1); cyc(0, 1, 5'h12, 0, 0, 0); idle(1);
    // R5 interrupt enable gates the pad
    curReq = "R5";
    cyc(1, 0, 5'h11, 16'h0001, 0, 0);
    cyc(0, 0, 5'h00, 0, 1, 1); idle(2);
    cyc(1, 0, 5'h11, 16'h0003, 0, 0); idle(1);
    // R2 output enable gates the pad; pad low in output role
    curReq = "R2";
    cyc(1, 0, 5'h11, 16'h0002, 0, 0); idle(4);
    cyc(1, 0, 5'h11, 16'h0003, 0, 0); idle(4);
    cyc(0, 1, 5'h12, 0, 0, 0); idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule